// File: doc/BRIEF.md
# Byte-Lane Memory Region Decoder

This block sits between a 16-bit processor core and a 64 KB byte-addressed memory space whose storage is physically organised as 16-bit words. For every access it classifies the byte address into one of five regions: peripheral registers, data RAM, an unmapped hole, program ROM or the interrupt vector table. It raises the matching select, or an error flag for the hole. It also presents the 15-bit word address to the storage arrays.

On writes it turns the access size into per-lane write enables and places the write byte on the correct half of the bus. Byte order is little-endian, so the byte at the even address occupies bits 7:0. Storage answers reads one cycle after the address. The block remembers the region, size and lane of each read for that cycle, picks the answering source, and for byte reads moves the addressed lane into bits 7:0 and clears bits 15:8. The RAM and ROM sizes are parameters. They must satisfy 0x200 + RAM_BYTES < 0x10000 - ROM_BYTES, and ROM_BYTES must be larger than 32.

Top module: `memmap_lane_decoder`

## Requirements
- R1: An enabled access raises exactly one of five indications. sel_per covers 0x0000..0x01FF. sel_ram covers 0x0200..0x0200+RAM_BYTES-1. sel_rom covers 0x10000-ROM_BYTES..0xFFDF. sel_vec covers 0xFFE0..0xFFFF. acc_gap_err covers every address between the RAM top and the ROM base.
- R2: mem_addr always equals acc_addr[15:1]. A word access at an odd byte address raises acc_misalign and is performed on the even word holding that byte.
- R3: A word write to a mapped region drives mem_we = 2'b11 and mem_wdata = acc_wdata, with bits 7:0 going to the even byte.
- R4: A byte write to a mapped region enables only one lane: mem_we = 2'b01 for an even address and 2'b10 for an odd address. acc_wdata[7:0] is copied onto both halves of mem_wdata.
- R5: A write into the unmapped hole raises acc_gap_err and drives mem_we = 2'b00, so the write is ignored.
- R6: A word read returns, on acc_rdata in the next cycle, the 16-bit word from the source of its region. per_rdata serves the peripheral region, ram_rdata serves RAM, and rom_rdata serves both ROM and vector addresses.
- R7: A byte read returns the addressed lane in acc_rdata[7:0] in the next cycle, using bits 7:0 of the word for an even address and bits 15:8 for an odd address. acc_rdata[15:8] is 0x00.
- R8: A read from the unmapped hole returns 0x0000 in the next cycle.
- R9: When acc_en is low, all selects, acc_gap_err, acc_misalign and mem_we are low. In the cycle after any cycle without a read, acc_rdata is 0x0000.
- R10: During reset, and in the first cycle after it, acc_rdata is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | Access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_byte | input | 1 | 1 = byte access, 0 = word access |
| acc_addr | input | 16 | Byte address |
| acc_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| acc_rdata | output | 16 | Read data, valid the cycle after a read |
| acc_gap_err | output | 1 | Access falls in the unmapped hole |
| acc_misalign | output | 1 | Word access at an odd address |
| sel_per | output | 1 | Peripheral region select |
| sel_ram | output | 1 | RAM region select |
| sel_rom | output | 1 | Program ROM region select |
| sel_vec | output | 1 | Vector table select |
| mem_addr | output | 15 | Word address to storage |
| mem_we | output | 2 | Per-lane write enables, bit 0 = even byte |
| mem_wdata | output | 16 | Lane-aligned write data |
| per_rdata | input | 16 | Peripheral word, one cycle after select |
| ram_rdata | input | 16 | RAM word, one cycle after select |
| rom_rdata | input | 16 | ROM and vector word, one cycle after select |

## Verification
The bench probes the last and first byte of every region edge: 0x01FF/0x0200, the RAM top, the ROM base, 0xFFDF/0xFFE0 and 0xFFFF. An off-by-one comparison there would route an access to the wrong array or report a false hole. Odd-address byte writes followed by reads of the word catch swapped lanes or a missing copy of the write byte, which would corrupt the neighbouring byte. Odd byte reads would expose a lane select that never shifts or that leaves stale upper bits. Misaligned word accesses, hole reads and hole writes check that the error case neither returns stale data nor damages storage. All of this runs under a long seeded random mix over all five regions.

// File: rtl/memmap_lane_decoder.sv
module memmap_lane_decoder #(
  parameter int RAM_BYTES = 1024,
  parameter int ROM_BYTES = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_en,
  input  logic        acc_wr,
  input  logic        acc_byte,
  input  logic [15:0] acc_addr,
  input  logic [15:0] acc_wdata,
  output logic [15:0] acc_rdata,
  output logic        acc_gap_err,
  output logic        acc_misalign,
  output logic        sel_per,
  output logic        sel_ram,
  output logic        sel_rom,
  output logic        sel_vec,
  output logic [14:0] mem_addr,
  output logic [1:0]  mem_we,
  output logic [15:0] mem_wdata,
  input  logic [15:0] per_rdata,
  input  logic [15:0] ram_rdata,
  input  logic [15:0] rom_rdata
);

  localparam logic [16:0] PER_TOP  = 17'h00200;
  localparam logic [16:0] RAM_TOP  = 17'(32'h200 + RAM_BYTES);
  localparam logic [16:0] ROM_BASE = 17'(32'h10000 - ROM_BYTES);
  localparam logic [16:0] VEC_BASE = 17'h0FFE0;

  typedef enum logic [1:0] {SRC_NONE, SRC_PER, SRC_RAM, SRC_ROM} rd_src_e;

  logic [16:0] a17;
  logic in_per, in_ram, in_rom, in_vec, in_gap;
  logic is_rd;
  rd_src_e q_src;
  logic    q_byte, q_hi;
  logic [15:0] rd_word;

  assign a17    = {1'b0, acc_addr};
  assign in_per = a17 < PER_TOP;
  assign in_ram = !in_per && (a17 < RAM_TOP);
  assign in_vec = a17 >= VEC_BASE;
  assign in_rom = !in_vec && (a17 >= ROM_BASE);
  assign in_gap = !(in_per || in_ram || in_rom || in_vec);

  assign sel_per      = acc_en && in_per;
  assign sel_ram      = acc_en && in_ram;
  assign sel_rom      = acc_en && in_rom;
  assign sel_vec      = acc_en && in_vec;
  assign acc_gap_err  = acc_en && in_gap;
  assign acc_misalign = acc_en && !acc_byte && acc_addr[0];
  assign mem_addr     = acc_addr[15:1];
  assign mem_wdata    = acc_byte ? {acc_wdata[7:0], acc_wdata[7:0]} : acc_wdata;

  always_comb begin
    mem_we = 2'b00;
    if (acc_en && acc_wr && !in_gap) begin
      if (!acc_byte)        mem_we = 2'b11;
      else if (acc_addr[0]) mem_we = 2'b10;
      else                  mem_we = 2'b01;
    end
  end

  assign is_rd = acc_en && !acc_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_src  <= SRC_NONE;
      q_byte <= 1'b0;
      q_hi   <= 1'b0;
    end else begin
      q_byte <= acc_byte;
      q_hi   <= acc_addr[0];
      if (!is_rd || in_gap)    q_src <= SRC_NONE;
      else if (in_per)         q_src <= SRC_PER;
      else if (in_ram)         q_src <= SRC_RAM;
      else                     q_src <= SRC_ROM;
    end
  end

  always_comb begin
    case (q_src)
      SRC_PER: rd_word = per_rdata;
      SRC_RAM: rd_word = ram_rdata;
      SRC_ROM: rd_word = rom_rdata;
      default: rd_word = 16'h0000;
    endcase
  end

  assign acc_rdata = q_byte ? {8'h00, (q_hi ? rd_word[15:8] : rd_word[7:0])} : rd_word;

  p_one_region_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |-> $countones({sel_per, sel_ram, acc_gap_err, sel_rom, sel_vec}) == 1);

  p_byte_one_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && acc_byte && !acc_gap_err) |->
      ($countones(mem_we) == 1 && mem_wdata[15:8] == mem_wdata[7:0]));

  p_gap_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_gap_err |-> mem_we == 2'b00);

  p_byte_zero_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_byte) |=> acc_rdata[15:8] == 8'h00);

  p_gap_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_gap_err) |=> acc_rdata == 16'h0000);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && !acc_wr) |=> acc_rdata == 16'h0000);

  p_idle_no_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |-> ({sel_per, sel_ram, sel_rom, sel_vec, acc_gap_err, acc_misalign} == 6'b0
                 && mem_we == 2'b00));

endmodule

// File: tb/memmap_lane_decoder_tb_top.sv
module memmap_lane_decoder_tb_top;
  localparam int RAM_BYTES = 1024;
  localparam int ROM_BYTES = 4096;
  localparam int RAM_TOP   = 'h200 + RAM_BYTES;
  localparam int ROM_BASE  = 'h10000 - ROM_BYTES;
  localparam int VEC_BASE  = 'hFFE0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_en = 1'b0, acc_wr = 1'b0, acc_byte = 1'b0;
  logic [15:0] acc_addr = '0, acc_wdata = '0;
  logic [15:0] acc_rdata;
  logic acc_gap_err, acc_misalign, sel_per, sel_ram, sel_rom, sel_vec;
  logic [14:0] mem_addr;
  logic [1:0]  mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] per_q = '0, ram_q = '0, rom_q = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  memmap_lane_decoder #(.RAM_BYTES(RAM_BYTES), .ROM_BYTES(ROM_BYTES)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_byte(acc_byte),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .acc_gap_err(acc_gap_err), .acc_misalign(acc_misalign), .sel_per(sel_per),
    .sel_ram(sel_ram), .sel_rom(sel_rom), .sel_vec(sel_vec), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .per_rdata(per_q), .ram_rdata(ram_q),
    .rom_rdata(rom_q));

  logic [15:0] m_per [256], m_ram [RAM_BYTES/2], m_rom [ROM_BYTES/2];
  logic [15:0] s_per [256], s_ram [RAM_BYTES/2], s_rom [ROM_BYTES/2];

  function automatic logic [15:0] seed_word(int rg, int i);
    return 16'((i * 40503 + rg * 4369 + 7) & 16'hFFFF);
  endfunction

  // behavioural storage, one-cycle read latency
  always @(posedge clk) begin
    int i;
    if (sel_per) begin
      i = int'(mem_addr) & 255;
      if (mem_we[0]) m_per[i][7:0]  <= mem_wdata[7:0];
      if (mem_we[1]) m_per[i][15:8] <= mem_wdata[15:8];
      per_q <= m_per[i];
    end
    if (sel_ram) begin
      i = int'(mem_addr) - ('h200 / 2);
      if (mem_we[0]) m_ram[i][7:0]  <= mem_wdata[7:0];
      if (mem_we[1]) m_ram[i][15:8] <= mem_wdata[15:8];
      ram_q <= m_ram[i];
    end
    if (sel_rom || sel_vec) begin
      i = int'(mem_addr) - (ROM_BASE / 2);
      if (mem_we[0]) m_rom[i][7:0]  <= mem_wdata[7:0];
      if (mem_we[1]) m_rom[i][15:8] <= mem_wdata[15:8];
      rom_q <= m_rom[i];
    end
  end

  // 0 per, 1 ram, 2 gap, 3 rom, 4 vec
  function automatic int region_of(logic [15:0] a);
    int v = int'(a);
    if (v < 'h200)     return 0;
    if (v < RAM_TOP)   return 1;
    if (v >= VEC_BASE) return 4;
    if (v >= ROM_BASE) return 3;
    return 2;
  endfunction

  function automatic logic [15:0] shadow_word(int rg, logic [15:0] a);
    int w = int'(a) >> 1;
    case (rg)
      0: return s_per[w & 255];
      1: return s_ram[w - 'h100];
      3, 4: return s_rom[w - ROM_BASE / 2];
      default: return 16'h0000;
    endcase
  endfunction

  task automatic shadow_store(int rg, logic [15:0] a, logic [15:0] v);
    int w = int'(a) >> 1;
    case (rg)
      0: s_per[w & 255] = v;
      1: s_ram[w - 'h100] = v;
      3, 4: s_rom[w - ROM_BASE / 2] = v;
      default: ;
    endcase
  endtask

  function automatic logic [15:0] exp_read(int rg, bit by, logic [15:0] a);
    logic [15:0] w;
    if (rg == 2) return 16'h0000;
    w = shadow_word(rg, a);
    if (by) return {8'h00, (a[0] ? w[15:8] : w[7:0])};
    return w;
  endfunction

  task automatic check(string req, bit ok, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(bit wr, bit by, logic [15:0] a, logic [15:0] d);
    int rg = region_of(a);
    logic [4:0] esel;
    logic [1:0] ewe;
    logic [15:0] erd, nw;
    @(negedge clk);
    acc_en = 1'b1; acc_wr = wr; acc_byte = by; acc_addr = a; acc_wdata = d;
    #1;
    esel = 5'b10000 >> rg;
    check("R1 region", {sel_per, sel_ram, acc_gap_err, sel_rom, sel_vec} == esel,
          32'({sel_per, sel_ram, acc_gap_err, sel_rom, sel_vec}), 32'(esel));
    check("R2 word address", mem_addr == a[15:1], 32'(mem_addr), 32'(a[15:1]));
    check("R2 misalign flag", acc_misalign == (!by && a[0]), 32'(acc_misalign), 32'(!by && a[0]));
    if (wr) begin
      if (rg == 2)      ewe = 2'b00;
      else if (!by)     ewe = 2'b11;
      else              ewe = a[0] ? 2'b10 : 2'b01;
      check(rg == 2 ? "R5 gap write lanes" : (by ? "R4 byte lanes" : "R3 word lanes"),
            mem_we == ewe, 32'(mem_we), 32'(ewe));
      if (rg != 2 && by)
        check("R4 byte replicated", mem_wdata == {d[7:0], d[7:0]}, 32'(mem_wdata), 32'({d[7:0], d[7:0]}));
      if (rg != 2 && !by)
        check("R3 word data", mem_wdata == d, 32'(mem_wdata), 32'(d));
    end else begin
      check("R9 read has no lanes", mem_we == 2'b00, 32'(mem_we), 32'h0);
    end
    erd = exp_read(rg, by, a);
    @(negedge clk);
    acc_en = 1'b0;
    if (!wr) begin
      check(rg == 2 ? "R8 gap read" : (by ? "R7 byte read" : "R6 word read"),
            acc_rdata == erd, 32'(acc_rdata), 32'(erd));
    end else begin
      check("R9 no read data after write", acc_rdata == 16'h0000, 32'(acc_rdata), 32'h0);
      if (rg != 2) begin
        nw = shadow_word(rg, a);
        if (!by)      nw = d;
        else if (a[0]) nw[15:8] = d[7:0];
        else           nw[7:0]  = d[7:0];
        shadow_store(rg, a, nw);
      end
    end
  endtask

  function automatic logic [15:0] rand_addr(int rg);
    case (rg)
      0: return 16'($urandom % 'h200);
      1: return 16'('h200 + $urandom % RAM_BYTES);
      2: return 16'(RAM_TOP + $urandom % (ROM_BASE - RAM_TOP));
      3: return 16'(ROM_BASE + $urandom % (VEC_BASE - ROM_BASE));
      default: return 16'(VEC_BASE + $urandom % 32);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin m_per[i] = seed_word(0, i); s_per[i] = m_per[i]; end
    for (int i = 0; i < RAM_BYTES/2; i++) begin m_ram[i] = seed_word(1, i); s_ram[i] = m_ram[i]; end
    for (int i = 0; i < ROM_BYTES/2; i++) begin m_rom[i] = seed_word(3, i); s_rom[i] = m_rom[i]; end

    repeat (3) @(negedge clk);
    check("R10 rdata in reset", acc_rdata == 16'h0000, 32'(acc_rdata), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 rdata after reset", acc_rdata == 16'h0000, 32'(acc_rdata), 32'h0);
    check("R9 idle selects", {sel_per, sel_ram, sel_rom, sel_vec, acc_gap_err, acc_misalign, mem_we} == 8'h00,
          32'({sel_per, sel_ram, sel_rom, sel_vec, acc_gap_err, acc_misalign, mem_we}), 32'h0);

    // region edges
    access(0, 0, 16'h01FE, 16'h0);
    access(0, 1, 16'h01FF, 16'h0);
    access(0, 1, 16'h0200, 16'h0);
    access(0, 0, 16'(RAM_TOP - 2), 16'h0);
    access(0, 1, 16'(RAM_TOP), 16'h0);
    access(0, 1, 16'(ROM_BASE - 1), 16'h0);
    access(0, 0, 16'(ROM_BASE), 16'h0);
    access(0, 1, 16'hFFDF, 16'h0);
    access(0, 1, 16'hFFE0, 16'h0);
    access(0, 0, 16'hFFFE, 16'h0);
    access(0, 1, 16'hFFFF, 16'h0);

    // lane steering in RAM
    access(1, 1, 16'h0301, 16'hA55A);
    access(0, 0, 16'h0300, 16'h0);
    access(1, 1, 16'h0300, 16'h3C77);
    access(0, 1, 16'h0300, 16'h0);
    access(0, 1, 16'h0301, 16'h0);
    access(0, 0, 16'h0300, 16'h0);

    // misaligned word write and read
    access(1, 0, 16'h0211, 16'hBEEF);
    access(0, 0, 16'h0210, 16'h0);
    access(0, 0, 16'h0211, 16'h0);

    // hole writes are dropped, reads return zero
    access(1, 0, 16'(RAM_TOP + 4), 16'hDEAD);
    access(0, 0, 16'(RAM_TOP + 4), 16'h0);
    access(1, 1, 16'(ROM_BASE - 1), 16'h00FF);
    access(0, 1, 16'(ROM_BASE - 1), 16'h0);

    // vector table word
    access(1, 0, 16'hFFFE, 16'h1234);
    access(0, 1, 16'hFFFF, 16'h0);

    for (int n = 0; n < 5000; n++) begin
      int rg = int'($urandom % 5);
      access(1'($urandom), 1'($urandom), rand_addr(rg), 16'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule